// File: doc/BRIEF.md
# Clear-on-Write Pulsed Interrupt Controller

This block gathers transfer events from a set of DMA channels into one status register and signals the CPU over a single interrupt line. Each data channel reports a start event and an end-of-data event. The bidirectional control endpoint uses two channels: its transmit channel reports only start, and its receive channel reports only end. With seven data channels this fills the 16 status bits exactly. A mask register decides which events are recorded. Events that are masked are dropped, not held back.

When a status bit is set, the block sends one pulse, one clock cycle long, on the interrupt line. It then locks: no further pulse comes until software writes the status register. That write clears every bit written as 1 and re-arms the pulse logic. If any bits are still set after the write, or new ones have arrived, the next pulse follows without any further action by software.

Top module: `ic_pulse_irq_ctrl`

## Requirements
- R1: After reset the status register and the mask register are both zero, `irq_o` is low, and the pulse logic is armed.
- R2: Status bit 0 records a control-transmit start. Bit 1 records a control-receive end. For data channel k (0..6), bit 2+2k records its start and bit 3+2k records its end.
- R3: A mask bit of 1 lets its event set the status bit. An event that arrives while its mask bit is 0 is discarded, and unmasking the bit later does not make that event appear.
- R4: `reg_addr_i` = 0 selects the status register and `reg_addr_i` = 1 selects the mask register. `reg_rdata_o` shows the selected register combinationally. A write to address 1 loads the mask.
- R5: A write to address 0 clears each status bit whose `reg_wdata_i` bit is 1 and leaves the bits written as 0 unchanged.
- R6: If an event sets a bit in the same cycle that a status write clears it, the bit ends up set.
- R7: When the logic is armed and the status is nonzero, `irq_o` goes high for exactly one cycle, on the clock edge after the one that set the status. This is the second cycle after the event input.
- R8: After a pulse, `irq_o` stays low, whatever new events arrive, until a write to address 0 takes place. Mask writes do not re-arm the logic.
- R9: No pulse is issued on the edge that samples a status write. If the status is nonzero after that write, `irq_o` pulses in the second cycle after the write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_tx_start_i | input | 1 | Control endpoint transmit channel start event |
| ctrl_rx_end_i | input | 1 | Control endpoint receive channel end-of-data event |
| data_start_i | input | NUM_DATA_CH | Start event per data channel |
| data_end_i | input | NUM_DATA_CH | End-of-data event per data channel |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 status, 1 mask |
| reg_wdata_i | input | 2+2*NUM_DATA_CH | Write data |
| reg_rdata_o | output | 2+2*NUM_DATA_CH | Read data of the selected register |
| irq_o | output | 1 | One-cycle interrupt pulse to the CPU |

## Verification
The bench goes after the lockout. It sends a second event after a pulse and expects no pulse. A design that re-armed on new status would fire again here. It also writes the status register with a bit left set and expects a fresh pulse two cycles later; a design that re-armed only on an empty status would stay silent. It drives a set and a clear on the same bit in one cycle, which catches a design that lets the clear win. It raises an event while its mask bit is 0 and then unmasks the bit, which exposes a design that latches masked events. A mid-run reset confirms that a locked controller comes back armed with both registers cleared.

// File: rtl/ic_pulse_irq_pkg.sv
package ic_pulse_irq_pkg;

  // Register select values on reg_addr_i.
  typedef enum logic {
    REG_STATUS = 1'b0,
    REG_MASK   = 1'b1
  } reg_sel_e;

  // Status bits taken by the control endpoint ahead of the data channels.
  localparam int CTRL_BITS     = 2;
  localparam int CTRL_TX_BIT   = 0;
  localparam int CTRL_RX_BIT   = 1;
  localparam int BITS_PER_CH   = 2;

endpackage

// File: rtl/ic_event_map.sv
module ic_event_map
  import ic_pulse_irq_pkg::*;
#(
  parameter int NUM_DATA_CH = 7,
  localparam int STAT_W = CTRL_BITS + BITS_PER_CH * NUM_DATA_CH
) (
  input  logic                   ctrl_tx_start_i,
  input  logic                   ctrl_rx_end_i,
  input  logic [NUM_DATA_CH-1:0] data_start_i,
  input  logic [NUM_DATA_CH-1:0] data_end_i,
  output logic [STAT_W-1:0]      raw_vec_o
);

  // Position of a data channel's start bit within the status vector.
  function automatic int start_pos(input int ch);
    return CTRL_BITS + BITS_PER_CH * ch;
  endfunction

  assign raw_vec_o[CTRL_TX_BIT] = ctrl_tx_start_i;
  assign raw_vec_o[CTRL_RX_BIT] = ctrl_rx_end_i;

  for (genvar k = 0; k < NUM_DATA_CH; k++) begin : g_data
    assign raw_vec_o[start_pos(k)]     = data_start_i[k];
    assign raw_vec_o[start_pos(k) + 1] = data_end_i[k];
  end

endmodule

// File: rtl/ic_reg_file.sv
module ic_reg_file
  import ic_pulse_irq_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_vec_i,
  input  logic         reg_wr_i,
  input  logic         reg_addr_i,
  input  logic [W-1:0] reg_wdata_i,
  output logic [W-1:0] reg_rdata_o,
  output logic [W-1:0] status_o,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] set_vec_o,
  output logic         stat_wr_o
);

  logic [W-1:0] status_q, mask_q;
  logic [W-1:0] clr_vec;
  logic         mask_wr;

  // Clear first, then set: an event in the same cycle wins.
  function automatic logic [W-1:0] next_status(input logic [W-1:0] cur,
                                               input logic [W-1:0] set,
                                               input logic [W-1:0] clr);
    return (cur & ~clr) | set;
  endfunction

  assign stat_wr_o = reg_wr_i && (reg_sel_e'(reg_addr_i) == REG_STATUS);
  assign mask_wr   = reg_wr_i && (reg_sel_e'(reg_addr_i) == REG_MASK);
  assign set_vec_o = raw_vec_i & mask_q;
  assign clr_vec   = stat_wr_o ? reg_wdata_i : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '0;
    end else begin
      status_q <= next_status(status_q, set_vec_o, clr_vec);
      if (mask_wr) mask_q <= reg_wdata_i;
    end
  end

  always_comb begin
    unique case (reg_sel_e'(reg_addr_i))
      REG_MASK: reg_rdata_o = mask_q;
      default:  reg_rdata_o = status_q;
    endcase
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;

endmodule

// File: rtl/ic_pulse_gen.sv
module ic_pulse_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic pending_i,
  input  logic stat_wr_i,
  output logic irq_o,
  output logic armed_o,
  output logic fire_o
);

  logic armed_q, irq_q;

  // Fire only when armed, something is pending and no acknowledge is in flight.
  assign fire_o = armed_q && pending_i && !stat_wr_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= fire_o;
      if (stat_wr_i)   armed_q <= 1'b1;
      else if (fire_o) armed_q <= 1'b0;
    end
  end

  assign irq_o   = irq_q;
  assign armed_o = armed_q;

endmodule

// File: rtl/ic_pulse_irq_ctrl.sv
module ic_pulse_irq_ctrl
  import ic_pulse_irq_pkg::*;
#(
  parameter int NUM_DATA_CH = 7,
  localparam int STAT_W = CTRL_BITS + BITS_PER_CH * NUM_DATA_CH
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ctrl_tx_start_i,
  input  logic                   ctrl_rx_end_i,
  input  logic [NUM_DATA_CH-1:0] data_start_i,
  input  logic [NUM_DATA_CH-1:0] data_end_i,
  input  logic                   reg_wr_i,
  input  logic                   reg_addr_i,
  input  logic [STAT_W-1:0]      reg_wdata_i,
  output logic [STAT_W-1:0]      reg_rdata_o,
  output logic                   irq_o
);

  logic [STAT_W-1:0] raw_vec, status_q, mask_q, set_vec;
  logic              stat_wr, armed_q, fire;

  ic_event_map #(.NUM_DATA_CH(NUM_DATA_CH)) u_map (
    .ctrl_tx_start_i (ctrl_tx_start_i),
    .ctrl_rx_end_i   (ctrl_rx_end_i),
    .data_start_i    (data_start_i),
    .data_end_i      (data_end_i),
    .raw_vec_o       (raw_vec)
  );

  ic_reg_file #(.W(STAT_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .raw_vec_i   (raw_vec),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .status_o    (status_q),
    .mask_o      (mask_q),
    .set_vec_o   (set_vec),
    .stat_wr_o   (stat_wr)
  );

  ic_pulse_gen u_pulse (
    .clk       (clk),
    .rst_n     (rst_n),
    .pending_i (|status_q),
    .stat_wr_i (stat_wr),
    .irq_o     (irq_o),
    .armed_o   (armed_q),
    .fire_o    (fire)
  );

endmodule

// File: rtl/ic_pulse_irq_chk.sv
module ic_pulse_irq_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         irq,
  input logic         stat_wr,
  input logic [W-1:0] status,
  input logic [W-1:0] mask,
  input logic [W-1:0] set_vec,
  input logic [W-1:0] wdata
);

  // Lockout tracker: set by a pulse, cleared by a status write.
  logic locked_q;
  always_ff @(posedge clk) begin
    if (!rst_n)       locked_q <= 1'b0;
    else if (stat_wr) locked_q <= 1'b0;
    else if (irq)     locked_q <= 1'b1;
  end

  // R7
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R7
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(|status));

  // R8
  lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |-> !irq);

  // R9
  ack_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr |=> !irq);

  // R5
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && set_vec == '0) |=> (status == ($past(status) & ~$past(wdata))));

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr |=> ((status & $past(set_vec)) == $past(set_vec)));

  // R3
  mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & ~$past(status) & ~$past(mask)) == '0));

endmodule

bind ic_pulse_irq_ctrl ic_pulse_irq_chk #(.W(STAT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .irq     (irq_o),
  .stat_wr (stat_wr),
  .status  (status_q),
  .mask    (mask_q),
  .set_vec (set_vec),
  .wdata   (reg_wdata_i)
);

// File: tb/ic_pulse_irq_ctrl_bench.sv
module ic_pulse_irq_ctrl_bench;

  localparam int ND = 7;
  localparam int W  = 2 + 2 * ND;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cs = 1'b0, ce = 1'b0;
  logic [ND-1:0] ds = '0, de = '0;
  logic          wr = 1'b0, ad = 1'b0;
  logic [W-1:0]  wd = '0;
  logic [W-1:0]  rd;
  logic          irq;

  always #5 clk = ~clk;

  ic_pulse_irq_ctrl #(.NUM_DATA_CH(ND)) u_ic_pulse_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .ctrl_tx_start_i(cs), .ctrl_rx_end_i(ce),
    .data_start_i(ds), .data_end_i(de), .reg_wr_i(wr), .reg_addr_i(ad),
    .reg_wdata_i(wd), .reg_rdata_o(rd), .irq_o(irq)
  );

  typedef struct packed {
    logic          cs;
    logic          ce;
    logic [ND-1:0] ds;
    logic [ND-1:0] de;
    logic          wr;
    logic          ad;
    logic [W-1:0]  wd;
    logic [W-1:0]  xs;   // expected status after the edge
    logic          xi;   // expected irq after the edge
  } vec_t;

  localparam int NV = 28;
  localparam vec_t TBL [NV] = '{
    '{1'b0,1'b0,7'h00,7'h00,1'b1,1'b1,16'hFFFF,16'h0000,1'b0}, // R4 mask all on
    '{1'b0,1'b0,7'h01,7'h00,1'b0,1'b0,16'h0000,16'h0004,1'b0}, // R2 data0 start -> bit2
    '{1'b0,1'b0,7'h00,7'h00,1'b0,1'b0,16'h0000,16'h0004,1'b1}, // R7 pulse
    '{1'b0,1'b0,7'h00,7'h00,1'b0,1'b0,16'h0000,16'h0004,1'b0}, // R7 one cycle
    '{1'b0,1'b0,7'h00,7'h02,1'b0,1'b0,16'h0000,16'h0024,1'b0}, // R2 data1 end -> bit5
    '{1'b0,1'b0,7'h00,7'h00,1'b0,1'b0,16'h0000,16'h0024,1'b0}, // R8 locked
    '{1'b0,1'b0,7'h00,7'h00,1'b1,1'b0,16'h0004,16'h0020,1'b0}, // R5 R9 ack bit2
    '{1'b0,1'b0,7'h00,7'h00,1'b0,1'b0,16'h0000,16'h0020,1'b1}, // R9 re-pulse
    '{1'b0,1'b0,7'h00,7'h00,1'b1,1'b0,16'h0020,16'h0000,1'b0}, // R5 clear all
    '{1'b0,1'b0,7'h00,7'h00,1'b0,1'b0,16'h0000,16'h0000,1'b0}, // R9 empty: no pulse
    '{1'b1,1'b1,7'h00,7'h00,1'b0,1'b0,16'h0000,16'h0003,1'b0}, // R2 ctrl bits
    '{1'b1,1'b0,7'h00,7'h00,1'b1,1'b0,16'h0001,16'h0003,1'b0}, // R6 set beats clear
    '{1'b0,1'b0,7'h00,7'h00,1'b0,1'b0,16'h0000,16'h0003,1'b1}, // R7 pulse
    '{1'b0,1'b0,7'h00,7'h00,1'b1,1'b1,16'h0000,16'h0003,1'b0}, // R8 mask write
    '{1'b0,1'b0,7'h00,7'h40,1'b0,1'b0,16'h0000,16'h0003,1'b0}, // R3 masked drop
    '{1'b0,1'b0,7'h00,7'h00,1'b1,1'b1,16'hFFFF,16'h0003,1'b0}, // R8 unmask, no rearm
    '{1'b0,1'b0,7'h00,7'h00,1'b0,1'b0,16'h0000,16'h0003,1'b0}, // R3 not revealed
    '{1'b0,1'b0,7'h00,7'h00,1'b1,1'b0,16'h0003,16'h0000,1'b0}, // R5 clear
    '{1'b0,1'b0,7'h00,7'h00,1'b0,1'b0,16'h0000,16'h0000,1'b0}, // R9 idle
    '{1'b0,1'b0,7'h00,7'h40,1'b0,1'b0,16'h0000,16'h8000,1'b0}, // R2 data6 end -> bit15
    '{1'b0,1'b0,7'h00,7'h00,1'b0,1'b0,16'h0000,16'h8000,1'b1}, // R7 pulse
    '{1'b0,1'b0,7'h00,7'h00,1'b0,1'b0,16'h0000,16'h8000,1'b0}, // R7 one cycle
    '{1'b0,1'b0,7'h40,7'h00,1'b1,1'b0,16'hFFFF,16'h4000,1'b0}, // R6 data6 start bit14
    '{1'b0,1'b0,7'h00,7'h00,1'b0,1'b0,16'h0000,16'h4000,1'b1}, // R9 re-pulse
    '{1'b0,1'b0,7'h00,7'h00,1'b1,1'b0,16'h4000,16'h0000,1'b0}, // R5 clear
    '{1'b0,1'b0,7'h00,7'h00,1'b1,1'b1,16'h0010,16'h0000,1'b0}, // R4 partial mask
    '{1'b0,1'b0,7'h06,7'h00,1'b0,1'b0,16'h0000,16'h0010,1'b0}, // R3 only bit4 kept
    '{1'b0,1'b0,7'h00,7'h00,1'b0,1'b0,16'h0000,16'h0010,1'b1}  // R7 pulse
  };

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    cs = 1'b0; ce = 1'b0; ds = '0; de = '0; wr = 1'b0; ad = 1'b0; wd = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 status", rd, '0);
    chk("R1 irq", {{(W-1){1'b0}}, irq}, '0);
    ad = 1'b1; #1;
    chk("R1 mask", rd, '0);
    ad = 1'b0;

    for (int i = 0; i < NV; i++) begin
      cs = TBL[i].cs; ce = TBL[i].ce; ds = TBL[i].ds; de = TBL[i].de;
      wr = TBL[i].wr; ad = TBL[i].ad; wd = TBL[i].wd;
      @(negedge clk);
      idle(); #1;
      chk($sformatf("R2/R9 row %0d status", i), rd, TBL[i].xs);
      chk($sformatf("R7/R8 row %0d irq", i), {{(W-1){1'b0}}, irq}, {{(W-1){1'b0}}, TBL[i].xi});
    end

    ad = 1'b1; #1;
    chk("R4 mask readback", rd, 16'h0010);
    ad = 1'b0;

    // Mid-run reset while locked and pending: R1
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); #1;
    chk("R1 status cleared", rd, '0);
    chk("R1 irq low", {{(W-1){1'b0}}, irq}, '0);
    rst_n = 1'b1; ad = 1'b1; #1;
    chk("R1 mask cleared", rd, '0);
    wr = 1'b1; wd = 16'hFFFF;
    @(negedge clk); idle();
    ce = 1'b1;
    @(negedge clk); idle(); #1;
    chk("R2 rx end bit1", rd, 16'h0002);
    chk("R1 armed no early irq", {{(W-1){1'b0}}, irq}, '0);
    @(negedge clk); #1;
    chk("R1 armed pulse", {{(W-1){1'b0}}, irq}, 16'h0001);
    @(negedge clk);
    finish_run();
  end

endmodule